// File: doc/BRIEF.md
# Interrupt Controller Command Interface

This block is the byte-wide, two-address programming port of an eight-line interrupt controller. Software writes a short initialization sequence to the port. The sequence sets the vector base, single or cascaded operation, fully nested mode and automatic end-of-interrupt. After that, software writes operation commands, which:
- load the mask,
- retire in-service lines, specifically or by priority,
- move the rotating priority base,
- choose which register a read returns,
- switch special mask mode,
- arm a poll.

The block holds the state that a separate priority resolver consumes: rotation base, mask, in-service vector, vector base and mode flags. It receives the resolver's current winner in return. On an interrupt acknowledge it presents the vector, which is the vector base followed by the winning line. If there is no winner, it reports line 7 as spurious. It also records the acknowledged line as in service, or, in automatic end-of-interrupt mode, optionally rotates the priority base past it. A read while a poll is armed returns the winner with bit 7 set and acknowledges that line in the same way.

Only one access is acted on per cycle. A write takes precedence over a read, and a read takes precedence over an acknowledge. The pending-request register lives outside the block and is only routed to the read port.

Top module: `intc_cmd_port`

## Requirements
- R1: After reset the mask, in-service vector, rotation base, vector base, nested, automatic end-of-interrupt and special mask outputs are zero, and `init_busy` is low.
- R2: A write to address 0 with bit 4 set clears the mask, in-service vector, rotation base, vector base, mode flags and an armed poll. It raises `init_busy`, latches "fourth word needed" from bit 0 and "single" from bit 1.
- R3: During initialization, the first write to address 1 stores bits 7:3 as the vector base. The next step is: the cascade word if not single; otherwise the fourth word if it is needed; otherwise done. After the cascade word, the next step is the fourth word if it is needed, otherwise done. The fourth word sets nested mode from bit 4 and automatic end-of-interrupt from bit 1, then ends initialization (`init_busy` low).
- R4: When `init_busy` is low, a write to address 1 loads the mask, and a non-poll read of address 1 returns the mask.
- R5: A write to address 0 with bit 4 clear and bit 3 set is a mode command. If bit 1 is set, bit 0 selects the address-0 read source: 1 selects the in-service vector, 0 selects `irr`. If bit 1 is clear, the selection is unchanged.
- R6: In the same mode command, bit 6 set loads special mask mode from bit 5. Bit 6 clear leaves it unchanged.
- R7: With bits 4 and 3 clear, command value 1 in bits 7:5 clears the in-service bit of highest priority. Priority runs from the line equal to the rotation base upward, modulo 8. Command value 5 also sets the base to that line plus 1. Both commands do nothing when no line is in service.
- R8: Command value 3 clears in-service bit `wdata[2:0]`. Command value 7 clears it and sets the base to `wdata[2:0]+1` modulo 8.
- R9: Command value 6 sets the base to `wdata[2:0]+1` modulo 8. Command values 0 and 4 set rotate-on-automatic-end-of-interrupt from bit 7.
- R10: An acknowledge with a valid winner sets that line's in-service bit when automatic end-of-interrupt is off. When it is on, the in-service vector is unchanged, and the base becomes the line plus 1 only if rotate-on-automatic-end-of-interrupt is set.
- R11: `vector` equals `{vec_base, line}`, where line is `win_line` when `win_valid` is high and 7 otherwise.
- R12: With a poll armed by bit 2 of a mode command, a read returns `0x80 | win_line` and acknowledges that line as in R10, or returns 0 when there is no winner. The poll is disarmed either way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effects only with poll armed) |
| addr | input | 1 | Port address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| irr | input | 8 | Pending-request register, for reads |
| win_valid | input | 1 | Resolver has a winner |
| win_line | input | 3 | Resolver's winning line |
| ack | input | 1 | Interrupt acknowledge |
| vector | output | 8 | Vector presented on acknowledge |
| imr | output | 8 | Mask register |
| isr | output | 8 | In-service vector |
| rot_base | output | 3 | Line holding highest priority |
| vec_base | output | 5 | Vector base, upper five bits |
| nested | output | 1 | Fully nested mode |
| auto_eoi | output | 1 | Automatic end-of-interrupt |
| special_mask | output | 1 | Special mask mode |
| init_busy | output | 1 | Initialization sequence in progress |

## Verification
The hardest case to reach from the ports is a priority-ordered end-of-interrupt. It depends on an arbitrary in-service pattern combined with an arbitrary rotation base, and the in-service vector can only be filled through acknowledges. The bench therefore places the base with the set-base command, then fills each of the 256 patterns by acknowledging one line per cycle. It then issues the end-of-interrupt and reads back both the in-service vector and the base, comparing them with an arithmetic search starting at the base. Between patterns, specific end-of-interrupt commands empty the vector again.

// File: rtl/intc_cmd_port.sv
module intc_cmd_port #(
  parameter int LINES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic                     addr,
  input  logic [7:0]               wdata,
  output logic [7:0]               rdata,
  input  logic [LINES-1:0]         irr,
  input  logic                     win_valid,
  input  logic [$clog2(LINES)-1:0] win_line,
  input  logic                     ack,
  output logic [7:0]               vector,
  output logic [LINES-1:0]         imr,
  output logic [LINES-1:0]         isr,
  output logic [$clog2(LINES)-1:0] rot_base,
  output logic [7-$clog2(LINES):0] vec_base,
  output logic                     nested,
  output logic                     auto_eoi,
  output logic                     special_mask,
  output logic                     init_busy
);
  localparam int LW = $clog2(LINES);

  localparam logic [1:0] ST_RUN  = 2'd0;
  localparam logic [1:0] ST_BASE = 2'd1;
  localparam logic [1:0] ST_CASC = 2'd2;
  localparam logic [1:0] ST_MODE = 2'd3;

  logic [1:0]    st_q;
  logic          need4_q, single_q, rot_aeoi_q, sel_isr_q, poll_q;
  logic [LW-1:0] top_line;
  logic          top_valid;

  assign init_busy = (st_q != ST_RUN);

  always_comb begin
    top_line  = '0;
    top_valid = 1'b0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (isr[rot_base + LW'(i)]) begin
        top_line  = rot_base + LW'(i);
        top_valid = 1'b1;
      end
    end
  end

  assign vector = {vec_base, (win_valid ? win_line : LW'(LINES - 1))};

  always_comb begin
    if (poll_q)
      rdata = win_valid ? (8'h80 | 8'(win_line)) : 8'h00;
    else if (addr)
      rdata = 8'(imr);
    else
      rdata = sel_isr_q ? 8'(isr) : 8'(irr);
  end

  logic       cmd_w, ocw3_w, icw1_w, data_w;
  logic [2:0] cmd;
  logic       take;

  assign icw1_w = wr_en && !addr && wdata[4];
  assign ocw3_w = wr_en && !addr && !wdata[4] && wdata[3];
  assign cmd_w  = wr_en && !addr && !wdata[4] && !wdata[3];
  assign data_w = wr_en && addr;
  assign cmd    = wdata[7:5];
  assign take   = !wr_en && ((rd_en && poll_q) || ack) && win_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= ST_RUN;
      imr          <= '0;
      isr          <= '0;
      rot_base     <= '0;
      vec_base     <= '0;
      nested       <= 1'b0;
      auto_eoi     <= 1'b0;
      special_mask <= 1'b0;
      need4_q      <= 1'b0;
      single_q     <= 1'b0;
      rot_aeoi_q   <= 1'b0;
      sel_isr_q    <= 1'b0;
      poll_q       <= 1'b0;
    end else if (icw1_w) begin
      st_q         <= ST_BASE;
      imr          <= '0;
      isr          <= '0;
      rot_base     <= '0;
      vec_base     <= '0;
      nested       <= 1'b0;
      auto_eoi     <= 1'b0;
      special_mask <= 1'b0;
      rot_aeoi_q   <= 1'b0;
      sel_isr_q    <= 1'b0;
      poll_q       <= 1'b0;
      need4_q      <= wdata[0];
      single_q     <= wdata[1];
    end else if (ocw3_w) begin
      if (wdata[2]) poll_q <= 1'b1;
      if (wdata[1]) sel_isr_q <= wdata[0];
      if (wdata[6]) special_mask <= wdata[5];
    end else if (cmd_w) begin
      case (cmd)
        3'd0, 3'd4: rot_aeoi_q <= cmd[2];
        3'd1, 3'd5: begin
          if (top_valid) begin
            isr[top_line] <= 1'b0;
            if (cmd[2]) rot_base <= top_line + 1'b1;
          end
        end
        3'd3: isr[wdata[LW-1:0]] <= 1'b0;
        3'd6: rot_base <= wdata[LW-1:0] + 1'b1;
        3'd7: begin
          isr[wdata[LW-1:0]] <= 1'b0;
          rot_base <= wdata[LW-1:0] + 1'b1;
        end
        default: ;
      endcase
    end else if (data_w) begin
      case (st_q)
        ST_RUN:  imr <= wdata[LINES-1:0];
        ST_BASE: begin
          vec_base <= wdata[7:LW];
          st_q <= single_q ? (need4_q ? ST_MODE : ST_RUN) : ST_CASC;
        end
        ST_CASC: st_q <= need4_q ? ST_MODE : ST_RUN;
        default: begin
          nested   <= wdata[4];
          auto_eoi <= wdata[1];
          st_q     <= ST_RUN;
        end
      endcase
    end else begin
      if (rd_en && poll_q) poll_q <= 1'b0;
      if (take) begin
        if (!auto_eoi)
          isr[win_line] <= 1'b1;
        else if (rot_aeoi_q)
          rot_base <= win_line + 1'b1;
      end
    end
  end
endmodule

// File: rtl/intc_cmd_port_chk.sv
module intc_cmd_port_chk #(
  parameter int LINES = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic                     rd_en,
  input logic                     ack,
  input logic                     addr,
  input logic [7:0]               wdata,
  input logic                     win_valid,
  input logic [$clog2(LINES)-1:0] win_line,
  input logic [LINES-1:0]         imr,
  input logic [LINES-1:0]         isr,
  input logic                     auto_eoi,
  input logic                     init_busy,
  input logic                     poll_q
);
  // R2
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4]) |=> (isr == '0 && imr == '0 && init_busy));

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && !init_busy) |=> (imr == $past(wdata[LINES-1:0])));

  // R7
  ns_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[7:3] == 5'b00100 && isr != '0)
      |=> ($countones(isr) == $countones($past(isr)) - 1));

  // R8
  spec_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[7:3] == 5'b01100) |=> !isr[$past(wdata[2:0])]);

  // R10
  ack_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && win_valid && !auto_eoi && !wr_en) |=> isr[$past(win_line)]);

  // R10
  aeoi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && auto_eoi && !wr_en) |=> $stable(isr));

  // R12
  poll_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && poll_q && !wr_en) |=> !poll_q);
endmodule

bind intc_cmd_port intc_cmd_port_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .ack(ack),
  .addr(addr), .wdata(wdata), .win_valid(win_valid), .win_line(win_line),
  .imr(imr), .isr(isr), .auto_eoi(auto_eoi), .init_busy(init_busy),
  .poll_q(poll_q)
);

// File: tb/sim_intc_cmd_port.sv
module sim_intc_cmd_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0, irr = '0;
  logic       win_valid = 1'b0;
  logic [2:0] win_line = '0;
  logic [7:0] rdata, vector, imr, isr;
  logic [2:0] rot_base;
  logic [4:0] vec_base;
  logic       nested, auto_eoi, special_mask, init_busy;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  intc_cmd_port u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irr(irr), .win_valid(win_valid),
    .win_line(win_line), .ack(ack), .vector(vector), .imr(imr), .isr(isr),
    .rot_base(rot_base), .vec_base(vec_base), .nested(nested),
    .auto_eoi(auto_eoi), .special_mask(special_mask), .init_busy(init_busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic do_ack(input logic [2:0] l);
    ack = 1'b1; win_valid = 1'b1; win_line = l;
    @(posedge clk); #1;
    ack = 1'b0; win_valid = 1'b0;
  endtask

  task automatic std_init(input logic aeoi);
    wr(0, 8'h11); wr(1, 8'h48); wr(1, 8'h00); wr(1, aeoi ? 8'h02 : 8'h00);
  endtask

  task automatic clear_isr();
    for (int i = 0; i < 8; i++) wr(0, 8'h60 | 8'(i));
  endtask

  task automatic fill_isr(input logic [7:0] p);
    for (int i = 0; i < 8; i++) if (p[i]) do_ack(3'(i));
  endtask

  function automatic int top_of(input logic [7:0] p, input int b);
    for (int i = 0; i < 8; i++) if (p[(b + i) % 8]) return (b + i) % 8;
    return -1;
  endfunction

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1
    chk("R1 imr", imr, 0); chk("R1 isr", isr, 0); chk("R1 base", rot_base, 0);
    chk("R1 vbase", vec_base, 0);
    chk("R1 flags", {nested, auto_eoi, special_mask, init_busy}, 0);

    // R2 R3 sweep over single and fourth-word options
    for (int s = 0; s < 2; s++) begin
      for (int f = 0; f < 2; f++) begin
        int n;
        wr(1, 8'hA5);
        wr(0, 8'h10 | 8'(s << 1) | 8'(f));
        chk("R2 busy", init_busy, 1); chk("R2 imr", imr, 0);
        wr(1, 8'h4D);
        chk("R3 vbase", vec_base, 9);
        n = 1;
        while (init_busy && n < 5) begin wr(1, 8'h12); n++; end
        chk("R3 steps", n, 1 + (s ? 0 : 1) + f);
        chk("R3 mode", {nested, auto_eoi}, f ? 3 : 0);
      end
    end

    // R4 mask sweep
    for (int m = 0; m < 256; m++) begin
      wr(1, 8'(m));
      chk("R4 imr", imr, m);
      addr = 1'b1; #1 chk("R4 read", rdata, m);
    end

    std_init(1'b0);
    // R5 read select
    fill_isr(8'h24); irr = 8'h81;
    addr = 1'b0;
    #1 chk("R5 default irr", rdata, 8'h81);
    wr(0, 8'h0B); #1 chk("R5 isr", rdata, 8'h24);
    wr(0, 8'h08); #1 chk("R5 kept", rdata, 8'h24);
    wr(0, 8'h0A); #1 chk("R5 irr", rdata, 8'h81);
    clear_isr();

    // R6 special mask
    wr(0, 8'h68); chk("R6 set", special_mask, 1);
    wr(0, 8'h28); chk("R6 kept", special_mask, 1);
    wr(0, 8'h48); chk("R6 clr", special_mask, 0);

    // R7 priority-ordered EOI over all bases and patterns
    for (int c = 0; c < 2; c++) begin
      for (int b = 0; b < 8; b++) begin
        for (int p = 0; p < 256; p += (c ? 7 : 1)) begin
          int t, eb;
          logic [7:0] ep;
          wr(0, 8'hC0 | 8'((b + 7) % 8));
          fill_isr(8'(p));
          wr(0, c ? 8'hA0 : 8'h20);
          t = top_of(8'(p), b);
          ep = 8'(p); eb = b;
          if (t >= 0) begin
            ep[t] = 1'b0;
            if (c) eb = (t + 1) % 8;
          end
          chk("R7 isr", isr, ep);
          chk("R7 base", rot_base, eb);
          clear_isr();
        end
      end
    end

    // R8 specific EOI
    fill_isr(8'hFF);
    wr(0, 8'h62); chk("R8 cmd3 isr", isr, 8'hFB);
    wr(0, 8'hE5); chk("R8 cmd7 isr", isr, 8'hDB); chk("R8 cmd7 base", rot_base, 6);
    clear_isr();
    // R9 set base
    for (int v = 0; v < 8; v++) begin
      wr(0, 8'hC0 | 8'(v)); chk("R9 base", rot_base, (v + 1) % 8);
    end

    // R10 acknowledge in automatic EOI
    std_init(1'b1);
    wr(0, 8'h80);
    do_ack(3'd4);
    chk("R10 aeoi isr", isr, 0); chk("R10 rotate", rot_base, 5);
    wr(0, 8'h00);
    do_ack(3'd2);
    chk("R10 norot", rot_base, 5);
    std_init(1'b0);
    do_ack(3'd3); chk("R10 set", isr, 8'h08);

    // R11 vector
    for (int l = 0; l < 8; l++) begin
      win_valid = 1'b1; win_line = 3'(l);
      #1 chk("R11 vector", vector, 8'h48 + l);
    end
    win_valid = 1'b0;
    #1 chk("R11 spurious", vector, 8'h4F);

    // R12 poll
    clear_isr();
    wr(0, 8'h0C);
    win_valid = 1'b1; win_line = 3'd6; addr = 1'b1;
    #1 chk("R12 poll data", rdata, 8'h86);
    rd_en = 1'b1; @(posedge clk); #1 rd_en = 1'b0; win_valid = 1'b0;
    chk("R12 acked", isr, 8'h40);
    wr(1, 8'h3C);
    addr = 1'b1; #1 chk("R12 disarmed", rdata, 8'h3C);
    wr(0, 8'h0C);
    #1 chk("R12 empty", rdata, 0);
    rd_en = 1'b1; @(posedge clk); #1 rd_en = 1'b0;
    addr = 1'b1; #1 chk("R12 empty disarm", rdata, 8'h3C);
    chk("R12 isr kept", isr, 8'h40);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule